// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns the addressing fields of an inter-processor or message-signalled interrupt into a per-processor delivery bitmask. It covers a fixed number of local interrupt controller slots. Each slot describes itself with four fields: a present flag, a physical ID, an 8-bit logical destination and a 4-bit destination-format model.

A request carries four fields: a destination byte, a physical/logical mode bit, a 2-bit shorthand and the index of the sending slot. It also carries a flag that asks for lowest-priority delivery. When that flag is set, the resolved set is reduced to one target: the lowest-numbered selected slot.

Requests enter through a valid/ready handshake. The mask leaves from one register stage through a second valid/ready pair. Interrupt injection and the storage of controller registers belong to the surrounding logic.

Top module: `ipi_target_resolver`

## Requirements
- R1: With the mode bit at 0 (physical) and shorthand 0, a destination byte of 8'hFF produces a mask with every bit set, whatever the present flags say.
- R2: With the mode bit at 0, shorthand 0 and any other destination byte, the mask holds exactly one bit. That bit belongs to the lowest-numbered scanned slot whose physical ID equals the byte. When no scanned slot matches, the mask is all zeros.
- R3: With the mode bit at 1 (logical) and shorthand 0, a scanned slot whose model is 4'hF is selected when its logical destination and the destination byte have at least one set bit in common.
- R4: With the mode bit at 1 and shorthand 0, a scanned slot whose model is 4'h0 is selected when two conditions hold: its logical destination's bits [7:4] equal the destination byte's bits [7:4], and bits [3:0] of the two have at least one set bit in common. A slot with any other model value is never selected in logical mode.
- R5: Physical and logical matching consider only slots below the lowest-numbered slot whose present flag is 0. That slot and every slot above it are never selected by those two lookups.
- R6: Shorthand 1 yields only the bit of the sender index, ignoring the destination byte and the mode bit.
- R7: Shorthand 2 yields every bit set. Shorthand 3 yields every bit set except the sender's bit. Both ignore the destination byte and the mode bit.
- R8: When the lowest-priority flag accompanies a request, only the lowest-numbered set bit of the resolved mask is kept. An all-zero mask stays all zeros.
- R9: The block takes a request at a clock edge where the input valid and the input ready are both high. The input ready is high while no result is held or the result is being taken. The result appears with the output valid one cycle after acceptance. It stays unchanged while the output ready is low. The mask reads zero once a result has been taken and no new request arrived.
- R10: After reset the output valid is low, the mask is zero and the input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be taken |
| destByte | input | 8 | Destination byte |
| logicalMode | input | 1 | 0 physical, 1 logical |
| shorthand | input | 2 | 0 normal, 1 self, 2 all, 3 all but self |
| senderIdx | input | $clog2(NUM_SLOTS) | Slot index of the sender |
| lowPri | input | 1 | Lowest-priority delivery reduction |
| slotPresent | input | NUM_SLOTS | Per-slot present flag |
| slotPhysId | input | NUM_SLOTS*8 | Per-slot physical ID, slot i at [i*8 +: 8] |
| slotLogDest | input | NUM_SLOTS*8 | Per-slot logical destination, slot i at [i*8 +: 8] |
| slotModel | input | NUM_SLOTS*4 | Per-slot format model, slot i at [i*4 +: 4] |
| outValid | output | 1 | Result held |
| outReady | input | 1 | Result taken |
| outMask | output | NUM_SLOTS | Delivery bitmask, bit i for slot i |

## Verification
The output register can hand a finished mask downstream in the same cycle that it loads the mask of a new request. This is the one place where draining and acceptance meet. The bench holds the output stalled with a request waiting at the input, and checks that the waiting request is refused and the old mask held. It then raises the output ready while that request is still offered, and checks that the next cycle shows the new request's mask with the output valid still high. A last idle cycle must leave the output empty.

// File: rtl/ipi_res_pkg.sv
package ipi_res_pkg;

  typedef struct packed {
    logic load;
    logic clear;
  } resStrobe_t;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;

endpackage

// File: rtl/ipi_res_ctrl.sv
module ipi_res_ctrl
  import ipi_res_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  output logic       inReady,
  input  logic       outReady,
  output logic       outValid,
  output resStrobe_t strobe
);

  logic accept;

  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  always_comb begin
    strobe       = '0;
    strobe.load  = accept;
    strobe.clear = outValid && outReady && !accept;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
    end else if (accept) begin
      outValid <= 1'b1;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // R9
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> outValid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid);

endmodule

// File: rtl/ipi_res_datapath.sv
module ipi_res_datapath
  import ipi_res_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 8,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  resStrobe_t                strobe,
  input  logic [ID_W-1:0]           destByte,
  input  logic                      logicalMode,
  input  logic [1:0]                shorthand,
  input  logic [IDX_W-1:0]          senderIdx,
  input  logic                      lowPri,
  input  logic [NUM_SLOTS-1:0]      slotPresent,
  input  logic [NUM_SLOTS*ID_W-1:0] slotPhysId,
  input  logic [NUM_SLOTS*ID_W-1:0] slotLogDest,
  input  logic [NUM_SLOTS*4-1:0]    slotModel,
  output logic [NUM_SLOTS-1:0]      outMask
);

  localparam int NIB = ID_W / 2;
  localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

  logic [NUM_SLOTS-1:0] reachable;
  logic [NUM_SLOTS-1:0] physHit;
  logic [NUM_SLOTS-1:0] logHit;
  logic [NUM_SLOTS-1:0] physMask;
  logic [NUM_SLOTS-1:0] routed;
  logic [NUM_SLOTS-1:0] selfBit;
  logic [NUM_SLOTS-1:0] chosen;
  logic [NUM_SLOTS-1:0] finalMask;

  // Scan stops at the first absent slot.
  always_comb begin
    logic run;
    run = 1'b1;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      run          = run & slotPresent[i];
      reachable[i] = run;
    end
  end

  // Per-slot matchers.
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    logic [ID_W-1:0] physId;
    logic [ID_W-1:0] logDest;
    logic [3:0]      model;
    logic            flatHit;
    logic            clusterHit;

    assign physId  = slotPhysId[g*ID_W +: ID_W];
    assign logDest = slotLogDest[g*ID_W +: ID_W];
    assign model   = slotModel[g*4 +: 4];

    assign flatHit    = (model == MODEL_FLAT) && ((destByte & logDest) != '0);
    assign clusterHit = (model == MODEL_CLUSTER)
                     && (destByte[ID_W-1:NIB] == logDest[ID_W-1:NIB])
                     && ((destByte[NIB-1:0] & logDest[NIB-1:0]) != '0);

    assign physHit[g] = reachable[g] && (physId == destByte);
    assign logHit[g]  = reachable[g] && (flatHit || clusterHit);
  end

  // Physical lookup keeps the first matching slot only.
  always_comb begin
    logic found;
    found    = 1'b0;
    physMask = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (physHit[i] && !found) begin
        physMask[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign selfBit = NUM_SLOTS'(1) << senderIdx;

  always_comb begin
    if (logicalMode) begin
      routed = logHit;
    end else if (destByte == BCAST) begin
      routed = '1;
    end else begin
      routed = physMask;
    end
  end

  always_comb begin
    unique case (shorthand_e'(shorthand))
      SH_NONE:   chosen = routed;
      SH_SELF:   chosen = selfBit;
      SH_ALL:    chosen = '1;
      SH_OTHERS: chosen = ~selfBit;
      default:   chosen = routed;
    endcase
  end

  assign finalMask = lowPri ? (chosen & (~chosen + NUM_SLOTS'(1))) : chosen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outMask <= '0;
    end else if (strobe.load) begin
      outMask <= finalMask;
    end else if (strobe.clear) begin
      outMask <= '0;
    end
  end

  // R8
  lowpri_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && lowPri) |=> $onehot0(outMask));

  // R2
  phys_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && !logicalMode && shorthand == 2'd0 && destByte != BCAST)
      |=> $onehot0(outMask));

  // R6
  self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && shorthand == 2'd1)
      |=> (outMask == (NUM_SLOTS'(1) << $past(senderIdx))));

  // R7
  others_exclude_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && shorthand == 2'd3 && !lowPri)
      |=> ($countones(outMask) == NUM_SLOTS - 1));

endmodule

// File: rtl/ipi_target_resolver.sv
module ipi_target_resolver
  import ipi_res_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int ID_W     = 8,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [ID_W-1:0]           destByte,
  input  logic                      logicalMode,
  input  logic [1:0]                shorthand,
  input  logic [IDX_W-1:0]          senderIdx,
  input  logic                      lowPri,
  input  logic [NUM_SLOTS-1:0]      slotPresent,
  input  logic [NUM_SLOTS*ID_W-1:0] slotPhysId,
  input  logic [NUM_SLOTS*ID_W-1:0] slotLogDest,
  input  logic [NUM_SLOTS*4-1:0]    slotModel,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [NUM_SLOTS-1:0]      outMask
);

  resStrobe_t strobe;

  ipi_res_ctrl uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inReady  (inReady),
    .outReady (outReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  ipi_res_datapath #(
    .NUM_SLOTS (NUM_SLOTS),
    .ID_W      (ID_W)
  ) uPath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .destByte    (destByte),
    .logicalMode (logicalMode),
    .shorthand   (shorthand),
    .senderIdx   (senderIdx),
    .lowPri      (lowPri),
    .slotPresent (slotPresent),
    .slotPhysId  (slotPhysId),
    .slotLogDest (slotLogDest),
    .slotModel   (slotModel),
    .outMask     (outMask)
  );

endmodule

// File: tb/tb_ipi_target_resolver.sv
module tb_ipi_target_resolver;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [7:0]   destByte = '0;
  logic         logicalMode = 1'b0;
  logic [1:0]   shorthand = '0;
  logic [2:0]   senderIdx = '0;
  logic         lowPri = 1'b0;
  logic [N-1:0] slotPresent;
  logic [N*8-1:0] slotPhysId;
  logic [N*8-1:0] slotLogDest;
  logic [N*4-1:0] slotModel;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [N-1:0] outMask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ipi_target_resolver #(.NUM_SLOTS(N)) dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .destByte(destByte), .logicalMode(logicalMode), .shorthand(shorthand),
    .senderIdx(senderIdx), .lowPri(lowPri), .slotPresent(slotPresent),
    .slotPhysId(slotPhysId), .slotLogDest(slotLogDest), .slotModel(slotModel),
    .outValid(outValid), .outReady(outReady), .outMask(outMask)
  );

  typedef struct packed {
    logic [7:0] dest;
    logic       mode;
    logic [1:0] sh;
    logic [2:0] snd;
    logic       lp;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'hFF, 1'b0, 2'd0, 3'd0, 1'b0, 8'hFF, 4'd1},  // R1 broadcast
    '{8'h13, 1'b0, 2'd0, 3'd0, 1'b0, 8'h08, 4'd2},  // R2 unicast
    '{8'h12, 1'b0, 2'd0, 3'd0, 1'b0, 8'h04, 4'd2},  // R2 duplicate ID, lowest wins
    '{8'h55, 1'b0, 2'd0, 3'd0, 1'b0, 8'h00, 4'd2},  // R2 no match
    '{8'h03, 1'b1, 2'd0, 3'd0, 1'b0, 8'h0B, 4'd3},  // R3 flat
    '{8'h33, 1'b1, 2'd0, 3'd0, 1'b0, 8'h3B, 4'd4},  // R4 cluster plus flat
    '{8'h42, 1'b1, 2'd0, 3'd0, 1'b0, 8'h02, 4'd4},  // R4 cluster lower nibble miss
    '{8'h41, 1'b1, 2'd0, 3'd0, 1'b0, 8'h49, 4'd4},  // R4 cluster hit
    '{8'h00, 1'b0, 2'd1, 3'd5, 1'b0, 8'h20, 4'd6},  // R6 self
    '{8'hFF, 1'b1, 2'd1, 3'd7, 1'b0, 8'h80, 4'd6},  // R6 dest ignored
    '{8'h13, 1'b0, 2'd2, 3'd0, 1'b0, 8'hFF, 4'd7},  // R7 all
    '{8'h13, 1'b1, 2'd3, 3'd0, 1'b0, 8'hFE, 4'd7},  // R7 all but self
    '{8'h33, 1'b1, 2'd0, 3'd0, 1'b1, 8'h01, 4'd8},  // R8 logical reduced
    '{8'h00, 1'b0, 2'd3, 3'd0, 1'b1, 8'h02, 4'd8},  // R8 others reduced
    '{8'h55, 1'b0, 2'd0, 3'd0, 1'b1, 8'h00, 4'd8},  // R8 empty stays empty
    '{8'h00, 1'b0, 2'd2, 3'd0, 1'b1, 8'h01, 4'd8}   // R8 all reduced
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setReq(input logic [7:0] d, input logic m, input logic [1:0] s,
                        input logic [2:0] snd, input logic lp);
    destByte = d; logicalMode = m; shorthand = s; senderIdx = snd; lowPri = lp;
  endtask

  task automatic configA();
    slotPresent = 8'hFF;
    for (int i = 0; i < N; i++) begin
      slotPhysId[i*8 +: 8] = 8'h10 + 8'(i);
      slotModel[i*4 +: 4]  = (i < 4) ? 4'hF : ((i < 7) ? 4'h0 : 4'h5);
    end
    slotPhysId[5*8 +: 8] = 8'h12;
    slotLogDest = {8'h31, 8'h41, 8'h32, 8'h31, 8'h81, 8'h04, 8'h02, 8'h01};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    configA();
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 outValid", 32'(outValid), 32'd0);
    check("R10 outMask", 32'(outMask), 32'd0);
    check("R10 inReady", 32'(inReady), 32'd1);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      setReq(VECS[v].dest, VECS[v].mode, VECS[v].sh, VECS[v].snd, VECS[v].lp);
      inValid = 1'b1;
      @(negedge clk);
      inValid = 1'b0;
      check($sformatf("R%0d vec%0d valid", VECS[v].req, v), 32'(outValid), 32'd1);
      check($sformatf("R%0d vec%0d mask", VECS[v].req, v), 32'(outMask), 32'(VECS[v].exp));
    end

    // R5 scan stops at absent slot 3
    slotPresent = 8'b1111_0111;
    @(negedge clk);
    setReq(8'h14, 1'b0, 2'd0, 3'd0, 1'b0); inValid = 1'b1;
    @(negedge clk); inValid = 1'b0;
    check("R5 phys beyond gap", 32'(outMask), 32'h00);
    setReq(8'hFF, 1'b1, 2'd0, 3'd0, 1'b0); inValid = 1'b1;
    @(negedge clk); inValid = 1'b0;
    check("R5 logical beyond gap", 32'(outMask), 32'h07);
    setReq(8'hFF, 1'b0, 2'd0, 3'd0, 1'b0); inValid = 1'b1;
    @(negedge clk); inValid = 1'b0;
    check("R1 broadcast with gap", 32'(outMask), 32'hFF);
    configA();

    // R9 stall, then accept and drain in one cycle
    @(negedge clk);
    outReady = 1'b0;
    setReq(8'h00, 1'b0, 2'd2, 3'd0, 1'b0); inValid = 1'b1;
    @(negedge clk);
    check("R9 stalled valid", 32'(outValid), 32'd1);
    check("R9 stalled mask", 32'(outMask), 32'hFF);
    check("R9 ready low", 32'(inReady), 32'd0);
    setReq(8'h00, 1'b0, 2'd1, 3'd3, 1'b0);
    @(negedge clk);
    check("R9 held mask", 32'(outMask), 32'hFF);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R9 swap valid", 32'(outValid), 32'd1);
    check("R9 swap mask", 32'(outMask), 32'h08);
    @(negedge clk);
    check("R9 drained valid", 32'(outValid), 32'd0);
    check("R9 drained mask", 32'(outMask), 32'h00);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule